// File: doc/BRIEF.md
# Four-Lane Byte/Word Buffer

This block is a first-in first-out data buffer whose storage is four independent byte lanes, each a small FIFO of `DEPTH` entries. A word port moves one byte into or out of every lane in the same cycle, so word traffic sees `LANES * DEPTH` bytes of room. A byte port moves one byte through lane 0 only, so byte traffic sees `DEPTH` bytes of room. A serial controller uses one copy on its transmit path and a second copy on its receive path.

Data moves over valid/ready streams. On the write side the producer raises `wr_*_valid` and the block answers with `wr_*_ready`. On the read side the block raises `rd_*_valid` with data already on the bus, and the consumer answers with `rd_*_ready`. A beat completes when both are high at a rising edge. This block does not stall a side that ignores back-pressure. A write offered while ready is low, or a read requested while valid is low, is dropped and raises the illegal-access flag. A producer or consumer must therefore wait for ready or valid before acting. When both ports of one direction are used in the same cycle, the word port wins. In that cycle the byte port shows not-ready.

Six level conditions feed a register of sticky status bits. Writing a one to a bit of `sts_clr` clears that bit. A bit whose condition still holds is set again on the next cycle. The interrupt output is level-high. It is the OR of the status bits that the enable mask selects. Out of reset the mask selects only the illegal-access bit. A soft reset empties every lane and clears every status bit, and it leaves the mask as it was.

Top module: `lane_fifo`

## Requirements
- R1: Each of the `LANES` lanes holds at most `DEPTH` bytes. A word write is accepted only when no lane is full. `DEPTH` word writes into an empty buffer fill it, and the next word write is refused.
- R2: An accepted word write puts data bits [8i+7:8i] into lane i. `rd_word_data` presents the oldest byte of lane i on bits [8i+7:8i]. Each lane keeps its own first-in first-out order.
- R3: The byte port writes to and reads from lane 0 only. `DEPTH` byte writes fill lane 0 and drop `wr_word_ready`, even while lanes 1 and up are empty. `rd_byte_valid` is low whenever lane 0 is empty.
- R4: When the word and byte ports of one direction are both requested in the same cycle, only the word access is performed. The byte port shows not-ready, and its request counts as an illegal access.
- R5: A write offered while its ready is low, or a read requested while its valid is low, changes no lane contents and sets status bit 5 (illegal access) one cycle later.
- R6: Each status bit is sticky and is set one cycle after its condition holds. Bit 0: every lane is empty. Bit 1: some lane holds at least `DEPTH/2`. Bit 2: some lane is full. Bit 3: every lane holds at least one byte (word available). Bit 4: lane 0 holds at least one byte (byte available). Bit 5: illegal access. Right after reset, status is 0.
- R7: A one in bit n of `sts_clr` clears status bit n at the next edge. If that bit's condition holds in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some status bit and its enable bit are both one. A pulse on `irq_en_we` loads the mask from `irq_en_data`. Reset loads the mask with only bit 5 set.
- R9: A cycle with `soft_rst` high empties all lanes and leaves status at 0 on the next cycle. The interrupt mask is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of lanes and status |
| wr_word_valid | input | 1 | Word write offered |
| wr_word_ready | output | 1 | Word write can be taken |
| wr_word_data | input | LANES*8 | Word write data, byte i to lane i |
| wr_byte_valid | input | 1 | Byte write offered |
| wr_byte_ready | output | 1 | Byte write can be taken |
| wr_byte_data | input | 8 | Byte write data |
| rd_word_valid | output | 1 | A full word is present |
| rd_word_ready | input | 1 | Consumer takes a word |
| rd_word_data | output | LANES*8 | Oldest byte of each lane |
| rd_byte_valid | output | 1 | Lane 0 holds a byte |
| rd_byte_ready | input | 1 | Consumer takes a byte |
| rd_byte_data | output | 8 | Oldest byte of lane 0 |
| sts_clr | input | 6 | Write-one-to-clear pulses for status bits |
| irq_en_we | input | 1 | Load strobe for the interrupt mask |
| irq_en_data | input | 6 | New interrupt mask |
| status | output | 6 | Sticky status bits |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest state to reach is lanes that are out of step with each other. In that state lane 0 is ahead of or behind the others, so the word and byte views of the buffer disagree. The stimulus gets there by mixing byte and word traffic. A byte read taken between word writes leaves a later word read with a byte from the next word in lane 0. Filling lane 0 alone through the byte port must block word writes while most of the storage is free. A cycle that drives both write ports at once shows that the byte beat is lost and only the illegal-access bit records it.

// File: rtl/lane_fifo_pkg.sv
package lane_fifo_pkg;
  localparam int NFLAG   = 6;
  localparam int FL_EMPTY = 0;
  localparam int FL_HALF  = 1;
  localparam int FL_FULL  = 2;
  localparam int FL_WORD  = 3;
  localparam int FL_BYTE  = 4;
  localparam int FL_ILL   = 5;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/lane_fifo_lane.sv
module lane_fifo_lane #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/lane_fifo_flags.sv
module lane_fifo_flags
  import lane_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  flag_vec_t cond,
  input  flag_vec_t clr,
  input  logic      en_we,
  input  flag_vec_t en_data,
  output flag_vec_t status,
  output logic      irq
);
  localparam flag_vec_t EN_RESET = flag_vec_t'(1) << FL_ILL;

  flag_vec_t en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      en_q   <= EN_RESET;
    end else begin
      if (soft_rst) status <= '0;
      else          status <= (status & ~clr) | cond;
      if (en_we)    en_q   <= en_data;
    end
  end

  assign irq = |(status & en_q);
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo
  import lane_fifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int W    = 8,
  localparam int WW   = LANES * W,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_word_valid,
  output logic             wr_word_ready,
  input  logic [WW-1:0]    wr_word_data,
  input  logic             wr_byte_valid,
  output logic             wr_byte_ready,
  input  logic [W-1:0]     wr_byte_data,
  output logic             rd_word_valid,
  input  logic             rd_word_ready,
  output logic [WW-1:0]    rd_word_data,
  output logic             rd_byte_valid,
  input  logic             rd_byte_ready,
  output logic [W-1:0]     rd_byte_data,
  input  logic [NFLAG-1:0] sts_clr,
  input  logic             irq_en_we,
  input  logic [NFLAG-1:0] irq_en_data,
  output logic [NFLAG-1:0] status,
  output logic             irq
);
  logic [LANES-1:0][CW-1:0] lane_cnt;
  logic [LANES-1:0][W-1:0]  lane_dout;
  logic [LANES-1:0]         lane_full, lane_half, lane_has;
  logic word_push, byte_push, word_pop, byte_pop, illegal;
  flag_vec_t cond;

  assign wr_word_ready = ~|lane_full;
  assign wr_byte_ready = !lane_full[0] && !wr_word_valid;
  assign rd_word_valid = &lane_has;
  assign rd_byte_valid = lane_has[0] && !rd_word_ready;

  assign word_push = wr_word_valid && wr_word_ready;
  assign byte_push = wr_byte_valid && wr_byte_ready;
  assign word_pop  = rd_word_ready && rd_word_valid;
  assign byte_pop  = rd_byte_ready && rd_byte_valid;

  assign illegal = (wr_word_valid && !wr_word_ready) ||
                   (wr_byte_valid && !wr_byte_ready) ||
                   (rd_word_ready && !rd_word_valid) ||
                   (rd_byte_ready && !rd_byte_valid);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          l_push, l_pop;
    logic [W-1:0]  l_din;
    if (g == 0) begin : g_shared
      assign l_push = word_push || byte_push;
      assign l_pop  = word_pop  || byte_pop;
      assign l_din  = word_push ? wr_word_data[g*W +: W] : wr_byte_data;
    end else begin : g_word_only
      assign l_push = word_push;
      assign l_pop  = word_pop;
      assign l_din  = wr_word_data[g*W +: W];
    end

    lane_fifo_lane #(.DEPTH(DEPTH), .W(W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (soft_rst),
      .push  (l_push),
      .din   (l_din),
      .pop   (l_pop),
      .dout  (lane_dout[g]),
      .count (lane_cnt[g])
    );

    assign lane_full[g] = (lane_cnt[g] == CW'(DEPTH));
    assign lane_half[g] = (lane_cnt[g] >= CW'(HALF));
    assign lane_has[g]  = (lane_cnt[g] != '0);
    assign rd_word_data[g*W +: W] = lane_dout[g];
  end

  assign rd_byte_data = lane_dout[0];

  always_comb begin
    cond           = '0;
    cond[FL_EMPTY] = ~|lane_has;
    cond[FL_HALF]  = |lane_half;
    cond[FL_FULL]  = |lane_full;
    cond[FL_WORD]  = &lane_has;
    cond[FL_BYTE]  = lane_has[0];
    cond[FL_ILL]   = illegal;
  end

  lane_fifo_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .cond     (cond),
    .clr      (sts_clr),
    .en_we    (irq_en_we),
    .en_data  (irq_en_data),
    .status   (status),
    .irq      (irq)
  );
endmodule

// File: rtl/lane_fifo_chk.sv
module lane_fifo_chk
  import lane_fifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     soft_rst,
  input logic                     wr_word_valid,
  input logic                     wr_word_ready,
  input logic                     wr_byte_valid,
  input logic                     wr_byte_ready,
  input logic                     rd_byte_valid,
  input logic [NFLAG-1:0]         status,
  input logic [LANES-1:0][CW-1:0] lane_cnt
);
  for (genvar g = 0; g < LANES; g++) begin : g_cap
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      lane_cnt[g] <= CW'(DEPTH)); // R1
  end

  AST_WORD_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_word_ready |-> (lane_cnt[LANES-1] < CW'(DEPTH))); // R1

  AST_WORD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_valid && wr_byte_valid) |-> !wr_byte_ready); // R4

  AST_LANE0_FEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_cnt[0] == '0) |-> !rd_byte_valid); // R3

  AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_valid && !wr_word_ready && !soft_rst) |=> status[FL_ILL]); // R5

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == '0)); // R9
endmodule

bind lane_fifo lane_fifo_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .wr_word_valid (wr_word_valid),
  .wr_word_ready (wr_word_ready),
  .wr_byte_valid (wr_byte_valid),
  .wr_byte_ready (wr_byte_ready),
  .rd_byte_valid (rd_byte_valid),
  .status        (status),
  .lane_cnt      (lane_cnt)
);

// File: tb/lane_fifo_bench.sv
module lane_fifo_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic wr_word_valid = 1'b0, wr_byte_valid = 1'b0;
  logic rd_word_ready = 1'b0, rd_byte_ready = 1'b0;
  logic [31:0] wr_word_data = '0;
  logic [7:0]  wr_byte_data = '0;
  logic [5:0]  sts_clr = '0, irq_en_data = '0;
  logic        irq_en_we = 1'b0;
  logic wr_word_ready, wr_byte_ready, rd_word_valid, rd_byte_valid, irq;
  logic [31:0] rd_word_data;
  logic [7:0]  rd_byte_data;
  logic [5:0]  status;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  lane_fifo #(.LANES(4), .DEPTH(DEPTH)) u_lane_fifo (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_word_valid(wr_word_valid), .wr_word_ready(wr_word_ready), .wr_word_data(wr_word_data),
    .wr_byte_valid(wr_byte_valid), .wr_byte_ready(wr_byte_ready), .wr_byte_data(wr_byte_data),
    .rd_word_valid(rd_word_valid), .rd_word_ready(rd_word_ready), .rd_word_data(rd_word_data),
    .rd_byte_valid(rd_byte_valid), .rd_byte_ready(rd_byte_ready), .rd_byte_data(rd_byte_data),
    .sts_clr(sts_clr), .irq_en_we(irq_en_we), .irq_en_data(irq_en_data),
    .status(status), .irq(irq)
  );

  localparam logic [2:0] OP_PW = 3'd0, OP_PB = 3'd1, OP_RW = 3'd2,
                         OP_RB = 3'd3, OP_ST = 3'd4, OP_CL = 3'd5;
  localparam int NV = 18;
  // {op, ok, data, expected}
  localparam logic [67:0] VEC [NV] = '{
    {OP_ST, 1'b1, 32'h0,        32'h01},        // R6 empty seen
    {OP_PW, 1'b1, 32'h44332211, 32'h0},         // R2
    {OP_PB, 1'b1, 32'hAA,       32'h0},         // R3
    {OP_ST, 1'b1, 32'h0,        32'h19},        // R6 sticky empty + word + byte
    {OP_CL, 1'b1, 32'h3F,       32'h0},         // R7
    {OP_ST, 1'b1, 32'h0,        32'h18},        // R7 held conditions return
    {OP_RW, 1'b1, 32'h0,        32'h44332211},  // R2
    {OP_RB, 1'b1, 32'h0,        32'hAA},        // R3
    {OP_RB, 1'b0, 32'h0,        32'h0},         // R5 read on empty
    {OP_CL, 1'b1, 32'h3F,       32'h0},         // R7
    {OP_ST, 1'b1, 32'h0,        32'h01},        // R6
    {OP_PW, 1'b1, 32'h0D0C0B0A, 32'h0},         // R2
    {OP_PW, 1'b1, 32'h1D1C1B1A, 32'h0},         // R2
    {OP_RB, 1'b1, 32'h0,        32'h0A},        // R3 lane 0 only
    {OP_RW, 1'b1, 32'h0,        32'h0D0C0B1A},  // R2 lanes out of step
    {OP_RW, 1'b0, 32'h0,        32'h0},         // R5 lane 0 empty
    {OP_CL, 1'b1, 32'h3F,       32'h0},         // R7
    {OP_ST, 1'b1, 32'h0,        32'h00}         // R6 no condition holds
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    wr_word_valid = 0; wr_byte_valid = 0; rd_word_ready = 0; rd_byte_ready = 0;
    sts_clr = '0; irq_en_we = 0; soft_rst = 0;
  endtask

  task automatic step(input logic [2:0] op, input bit ok, input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    case (op)
      OP_PW: begin wr_word_valid = 1; wr_word_data = d; #1
        chk(wr_word_ready == ok, "R1 word write ready", 32'(wr_word_ready), 32'(ok)); end
      OP_PB: begin wr_byte_valid = 1; wr_byte_data = d[7:0]; #1
        chk(wr_byte_ready == ok, "R3 byte write ready", 32'(wr_byte_ready), 32'(ok)); end
      OP_RW: begin rd_word_ready = 1; #1
        chk(rd_word_valid == ok, "R2 word read valid", 32'(rd_word_valid), 32'(ok));
        if (ok) chk(rd_word_data == e, "R2 word read data", rd_word_data, e); end
      OP_RB: begin rd_byte_ready = 1; #1
        chk(rd_byte_valid == ok, "R3 byte read valid", 32'(rd_byte_valid), 32'(ok));
        if (ok) chk(rd_byte_data == e[7:0], "R3 byte read data", 32'(rd_byte_data), e); end
      OP_ST: begin #1 chk(status == e[5:0], "R6 status", 32'(status), e); end
      default: sts_clr = d[5:0];
    endcase
    @(posedge clk); #1 quiet();
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(status == 6'h00, "R6 reset status", 32'(status), 32'h0);
    chk(irq == 0, "R8 reset irq", 32'(irq), 0);
    chk(wr_word_ready && wr_byte_ready, "R1 reset write ready", 32'(wr_word_ready), 1);
    chk(!rd_word_valid && !rd_byte_valid, "R3 reset read valid", 32'(rd_byte_valid), 0);
    @(posedge clk);

    for (int i = 0; i < NV; i++) step(VEC[i][67:65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);

    // R9 soft reset
    @(negedge clk); soft_rst = 1;
    @(posedge clk); #1 soft_rst = 0;
    @(negedge clk);
    chk(status == 6'h00, "R9 status after soft reset", 32'(status), 0);
    chk(!rd_word_valid && !rd_byte_valid, "R9 lanes empty", 32'(rd_word_valid), 0);
    @(posedge clk);

    // R3 byte port fills lane 0 alone
    for (int i = 0; i < DEPTH; i++) step(OP_PB, 1'b1, 32'(i + 8'h40), 32'h0);
    @(negedge clk);
    chk(!wr_word_ready, "R3 word blocked by lane 0", 32'(wr_word_ready), 0);
    chk((status & 6'h16) == 6'h16, "R6 full half byte", 32'(status), 32'h16);
    chk(irq == 0, "R8 irq quiet before error", 32'(irq), 0);
    step(OP_PB, 1'b0, 32'h99, 32'h0);
    @(negedge clk);
    chk(status[5] && irq, "R8 illegal raises irq", 32'(irq), 1);
    chk(rd_byte_data == 8'h40, "R5 rejected byte did not land", 32'(rd_byte_data), 32'h40);

    // R8 mask change
    step(OP_CL, 1'b1, 32'h3F, 32'h0);
    @(negedge clk); irq_en_we = 1; irq_en_data = 6'h04;
    @(posedge clk); #1 quiet();
    @(negedge clk);
    chk(status == 6'h16 && irq, "R8 full enabled", 32'(status), 32'h16);
    irq_en_we = 1; irq_en_data = 6'h00;
    @(posedge clk); #1 quiet();
    @(negedge clk);
    chk(irq == 0, "R8 masked", 32'(irq), 0);
    irq_en_we = 1; irq_en_data = 6'h04;
    @(posedge clk); #1 quiet();

    // R4 collision
    @(negedge clk); soft_rst = 1;
    @(posedge clk); #1 quiet();
    @(negedge clk);
    wr_word_valid = 1; wr_word_data = 32'hCAFE0150; wr_byte_valid = 1; wr_byte_data = 8'h77;
    #1 chk(wr_word_ready && !wr_byte_ready, "R4 word wins", 32'(wr_byte_ready), 0);
    @(posedge clk); #1 quiet();
    @(posedge clk);
    @(negedge clk);
    chk(status[5], "R4 dropped byte flagged", 32'(status), 32'h20);
    step(OP_RW, 1'b1, 32'h0, 32'hCAFE0150);
    @(negedge clk);
    chk(!rd_byte_valid, "R4 byte never stored", 32'(rd_byte_valid), 0);

    // R1 word fill, mask kept across soft reset (R9)
    soft_rst = 1;
    @(posedge clk); #1 quiet();
    for (int i = 0; i < DEPTH; i++) step(OP_PW, 1'b1, 32'h10203040 + 32'(i), 32'h0);
    @(negedge clk);
    chk(irq, "R9 mask kept, full interrupts", 32'(irq), 1);
    step(OP_PW, 1'b0, 32'hDEAD, 32'h0);
    for (int i = 0; i < DEPTH; i++) step(OP_RW, 1'b1, 32'h0, 32'h10203040 + 32'(i));
    step(OP_RW, 1'b0, 32'h0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule